// File: doc/BRIEF.md
# Direct-Mapped Split-Permission Translation Buffer

This block caches virtual-to-physical page mappings for a processor's instruction fetch, load and store accesses. It holds one shared array of physical page numbers and three separate tag arrays, one for each access kind. A request is looked up in one cycle. On a hit the physical address is returned on the next clock. On a miss the block stalls the requester and asks an external page-table walker for the page table entry.

When the walker answers, the block checks the permissions in the returned entry against the access kind. In supervisor mode the supervisor permission bits stand in for the user bits. A failed check returns an access fault of the matching kind, records the virtual address for data faults and installs nothing. A passing entry is installed in each tag array whose access kind the page allows. The other arrays at that index get an all-ones invalid marker. Because permissions are settled at install time, a later hit needs no permission logic. A flush input clears every tag in all three arrays at once. A change of privilege mode takes effect for cached pages only after a flush.

Top module: `xlat_buf`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `walk_req` are 0 and `bad_vaddr` is 0. Every tag holds the all-ones invalid marker, so the first access to any address misses. This includes the address 0xFFFFFFFF, which must not match an invalid marker.
- R2: The entry index is virtual address bits [15:12] (page number modulo 16). The tag is the virtual address with bits [11:0] cleared. A request hits only when the tag array of its kind holds exactly its tag. A page with the same index and a different tag misses, and on a successful refill it replaces the old entry.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. On a hit, `resp_valid` is 1 in the following cycle with `resp_fault` 0 and `resp_paddr` = {stored page number, virtual address bits [11:0]}, and no walk is started.
- R4: On a miss, `walk_req` is 1 from the next cycle with `walk_vaddr` equal to the request address, and it stays so until the cycle in which `walk_valid` is 1. `req_ready` is 0 while `walk_req` is 1. `resp_valid` is 1 in the cycle after `walk_valid`, and `walk_req` is 0 in that cycle.
- R5: `req_kind` 0 is a load, 1 is a store, and 2 or 3 is a fetch. The walker's entry carries bit 0 = entry valid, bits 1/2/3 = user read/write/execute, bits 4/5/6 = supervisor read/write/execute, bit 7 unused, and bits [27:8] = physical page number. A load needs read permission, a store needs write permission and a fetch needs execute permission. Every access also needs the entry valid bit.
- R6: When `supv` is 1 at acceptance, the supervisor bits (4..6) are used in place of the user bits (1..3) for both the check and the install. The entry valid bit is used unchanged. When `supv` is 0, the user bits are used.
- R7: A failed check gives `resp_valid` 1 with `resp_fault` = 1 for a load, 2 for a store and 3 for a fetch. It installs nothing, so the entry at that index keeps its earlier contents.
- R8: A successful refill returns the physical address {entry page number, offset} and writes the tag only into the arrays whose permission the page grants. A later access of a kind that was not granted misses and walks again.
- R9: `bad_vaddr` takes the faulting virtual address on load and store faults and keeps its value on fetch faults and on successful accesses.
- R10: While `flush` is 1, `req_ready` is 0. A flush marks every tag of all three arrays invalid, and the next access to a formerly cached page misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all tags |
| supv | input | 1 | Supervisor mode for the request being accepted |
| req_valid | input | 1 | Translation request present |
| req_kind | input | 2 | 0 load, 1 store, 2/3 fetch |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Request can be accepted this cycle |
| resp_valid | output | 1 | Response present |
| resp_fault | output | 2 | 0 none, 1 load fault, 2 store fault, 3 fetch fault |
| resp_paddr | output | 32 | Translated physical address |
| walk_req | output | 1 | Refill requested from the walker |
| walk_vaddr | output | 32 | Address the walker should translate |
| walk_valid | input | 1 | Walker returns an entry |
| walk_pte | input | 28 | Page table entry from the walker |
| bad_vaddr | output | 32 | Last faulting load/store virtual address |

## Verification
The bench checks that the split tag arrays really hold separate permissions. A read/write page must hit for loads and stores but walk again for fetches. A design with one shared tag would hit there and return an address it should have refused. It makes two pages share an index so that a wrong index or tag slice shows up as a false hit. It faults on an entry that already holds a valid neighbour, because a design that installs on fault would destroy that neighbour's mapping. It runs the supervisor remap in both directions, as well as entries without the valid bit. It checks that only data faults move `bad_vaddr`, that a flush arriving together with a request holds the request back and forces a miss afterwards, and that the all-ones address misses after a flush.

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int PTE_W    = PPN_W + 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             supv,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             resp_valid,
  output logic [1:0]       resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             walk_req,
  output logic [VA_W-1:0]  walk_vaddr,
  input  logic             walk_valid,
  input  logic [PTE_W-1:0] walk_pte,
  output logic [VA_W-1:0]  bad_vaddr
);
  localparam logic [VA_W-1:0] OFS_MASK = {{(VA_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};
  localparam logic [VA_W-1:0] NO_TAG   = '1;

  logic [VA_W-1:0]  tag_ld [ENTRIES];
  logic [VA_W-1:0]  tag_st [ENTRIES];
  logic [VA_W-1:0]  tag_fx [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];

  logic            busy;
  logic [VA_W-1:0] hold_va;
  logic [1:0]      hold_kind;
  logic            hold_supv;

  wire [IDX_W-1:0] req_idx  = req_vaddr[PAGE_BITS +: IDX_W];
  wire [VA_W-1:0]  req_tag  = req_vaddr & ~OFS_MASK;
  wire [IDX_W-1:0] hold_idx = hold_va[PAGE_BITS +: IDX_W];
  wire [VA_W-1:0]  hold_tag = hold_va & ~OFS_MASK;

  wire [VA_W-1:0] look_tag = req_kind[1] ? tag_fx[req_idx] :
                             req_kind[0] ? tag_st[req_idx] : tag_ld[req_idx];
  wire hit    = (look_tag == req_tag);
  wire accept = req_valid && req_ready;
  wire done   = busy && walk_valid;

  // permissions as {x, w, r}; supervisor bits replace user bits
  wire [2:0] perm   = hold_supv ? walk_pte[6:4] : walk_pte[3:1];
  wire       ent_ok = walk_pte[0];
  wire       h_fx   = hold_kind[1];
  wire       h_st   = !hold_kind[1] && hold_kind[0];
  wire       need   = h_fx ? perm[2] : h_st ? perm[1] : perm[0];
  wire       deny   = !ent_ok || !need;
  wire [1:0] code   = h_fx ? 2'd3 : h_st ? 2'd2 : 2'd1;
  wire       install = done && !deny && !flush;

  assign req_ready  = !busy && !flush;
  assign walk_req   = busy;
  assign walk_vaddr = hold_va;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      hold_va    <= '0;
      hold_kind  <= '0;
      hold_supv  <= 1'b0;
      resp_valid <= 1'b0;
      resp_fault <= '0;
      resp_paddr <= '0;
      bad_vaddr  <= '0;
    end else begin
      resp_valid <= (accept && hit) || done;
      resp_fault <= (done && deny) ? code : 2'd0;
      if (done)
        resp_paddr <= {walk_pte[PTE_W-1:8], hold_va[PAGE_BITS-1:0]};
      else
        resp_paddr <= {ppn_q[req_idx], req_vaddr[PAGE_BITS-1:0]};
      if (accept && !hit) begin
        busy      <= 1'b1;
        hold_va   <= req_vaddr;
        hold_kind <= req_kind;
        hold_supv <= supv;
      end else if (done) begin
        busy <= 1'b0;
      end
      if (done && deny && !h_fx)
        bad_vaddr <= hold_va;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    wire sel = install && (hold_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        tag_ld[i] <= NO_TAG;
        tag_st[i] <= NO_TAG;
        tag_fx[i] <= NO_TAG;
      end else if (sel) begin
        tag_ld[i] <= perm[0] ? hold_tag : NO_TAG;
        tag_st[i] <= perm[1] ? hold_tag : NO_TAG;
        tag_fx[i] <= perm[2] ? hold_tag : NO_TAG;
      end
    end
    always_ff @(posedge clk) begin
      if (sel) ppn_q[i] <= walk_pte[PTE_W-1:8];
    end
  end
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_ready,
  input logic            resp_valid,
  input logic [1:0]      resp_fault,
  input logic            walk_req,
  input logic            walk_valid,
  input logic [VA_W-1:0] walk_vaddr,
  input logic [VA_W-1:0] bad_vaddr
);
  a_r4_stall_while_walking: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready);

  a_r4_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !walk_valid |=> walk_req && $stable(walk_vaddr));

  a_r4_walk_ends: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && walk_valid |=> resp_valid && !walk_req);

  a_r7_fault_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault != 2'd0 |-> resp_valid);

  a_r9_fetch_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault == 2'd3 |-> $stable(bad_vaddr));

  a_r9_data_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_fault == 2'd1 || resp_fault == 2'd2) |-> bad_vaddr == $past(walk_vaddr));

  a_r10_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);
endmodule

bind xlat_buf xlat_buf_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_fault(resp_fault), .walk_req(walk_req),
  .walk_valid(walk_valid), .walk_vaddr(walk_vaddr), .bad_vaddr(bad_vaddr)
);

// File: tb/sim_xlat_buf.sv
`timescale 1ns/1ps
module sim_xlat_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, supv = 1'b0, req_valid = 1'b0, walk_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [31:0] req_vaddr = '0;
  logic [27:0] walk_pte = '0;
  logic        req_ready, resp_valid, walk_req;
  logic [1:0]  resp_fault;
  logic [31:0] resp_paddr, walk_vaddr, bad_vaddr;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  xlat_buf u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .supv(supv),
    .req_valid(req_valid), .req_kind(req_kind), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .walk_req(walk_req), .walk_vaddr(walk_vaddr),
    .walk_valid(walk_valid), .walk_pte(walk_pte), .bad_vaddr(bad_vaddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: behavioural, updated on every rising edge
  logic [31:0] m_tl [16], m_ts [16], m_tf [16];
  logic [19:0] m_pg [16];
  bit          m_busy, e_rv, m_sv;
  logic [1:0]  m_kind, e_fc;
  logic [31:0] m_va, e_pa, m_bad;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_tl[i] = '1; m_ts[i] = '1; m_tf[i] = '1; end
      m_busy = 0; e_rv = 0; e_fc = 0; m_bad = 0; m_va = 0;
    end else begin
      e_rv = 0; e_fc = 0;
      if (m_busy) begin
        if (walk_valid) begin
          bit r, w, x, ok;
          int ix;
          r = m_sv ? walk_pte[4] : walk_pte[1];
          w = m_sv ? walk_pte[5] : walk_pte[2];
          x = m_sv ? walk_pte[6] : walk_pte[3];
          ok = walk_pte[0] && (m_kind >= 2 ? x : m_kind == 1 ? w : r);
          e_rv = 1;
          ix = int'(m_va[15:12]);
          if (ok) begin
            e_pa = {walk_pte[27:8], m_va[11:0]};
            m_tl[ix] = r ? {m_va[31:12], 12'h0} : '1;
            m_ts[ix] = w ? {m_va[31:12], 12'h0} : '1;
            m_tf[ix] = x ? {m_va[31:12], 12'h0} : '1;
            m_pg[ix] = walk_pte[27:8];
          end else begin
            e_fc = m_kind >= 2 ? 2'd3 : m_kind == 1 ? 2'd2 : 2'd1;
            if (m_kind < 2) m_bad = m_va;
          end
          m_busy = 0;
        end
      end else if (req_valid && !flush) begin
        int ix;
        logic [31:0] t, tg;
        ix = int'(req_vaddr[15:12]);
        tg = {req_vaddr[31:12], 12'h0};
        t = req_kind >= 2 ? m_tf[ix] : req_kind == 1 ? m_ts[ix] : m_tl[ix];
        if (t == tg) begin
          e_rv = 1; e_pa = {m_pg[ix], req_vaddr[11:0]};
        end else begin
          m_busy = 1; m_va = req_vaddr; m_kind = req_kind; m_sv = supv;
        end
      end
      if (flush)
        for (int i = 0; i < 16; i++) begin m_tl[i] = '1; m_ts[i] = '1; m_tf[i] = '1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(resp_valid == e_rv, "R3/R4 resp_valid", 32'(resp_valid), 32'(e_rv));
      if (e_rv) chk(resp_fault == e_fc, "R7 resp_fault", 32'(resp_fault), 32'(e_fc));
      if (e_rv && e_fc == 0) chk(resp_paddr == e_pa, "R3 resp_paddr", resp_paddr, e_pa);
      chk(walk_req == m_busy, "R4 walk_req", 32'(walk_req), 32'(m_busy));
      if (m_busy) chk(walk_vaddr == m_va, "R4 walk_vaddr", walk_vaddr, m_va);
      chk(req_ready == (!m_busy && !flush), "R10 req_ready", 32'(req_ready), 32'(!m_busy && !flush));
      chk(bad_vaddr == m_bad, "R9 bad_vaddr", bad_vaddr, m_bad);
    end
  end

  function automatic logic [27:0] mkpte(input logic [19:0] pg, input logic [6:0] bits);
    return {pg, 1'b0, bits};
  endfunction

  localparam logic [6:0] E = 7'h01, UR = 7'h02, UW = 7'h04, UX = 7'h08,
                         SR = 7'h10, SW = 7'h20, SX = 7'h40;

  task automatic serve_walk(input logic [27:0] pte);
    repeat (2) begin @(posedge clk); #1; end
    walk_valid = 1; walk_pte = pte;
    @(posedge clk); #1;
    walk_valid = 0;
  endtask

  task automatic access(input logic [1:0] k, input logic [31:0] va, input bit sv,
                        input logic [27:0] pte, input bit exp_walk,
                        input logic [1:0] exp_fc, input logic [31:0] exp_pa, input string tag);
    bit walked;
    @(posedge clk); #1;
    req_valid = 1; req_kind = k; req_vaddr = va; supv = sv;
    @(posedge clk); #1;
    req_valid = 0;
    walked = walk_req;
    chk(walked == exp_walk, {tag, " walk started"}, 32'(walked), 32'(exp_walk));
    if (walked) serve_walk(pte);
    chk(resp_valid == 1'b1, {tag, " resp_valid"}, 32'(resp_valid), 32'd1);
    chk(resp_fault == exp_fc, {tag, " fault code"}, 32'(resp_fault), 32'(exp_fc));
    if (exp_fc == 0) chk(resp_paddr == exp_pa, {tag, " paddr"}, resp_paddr, exp_pa);
  endtask

  bit fin = 0;
  initial begin
    #(4 * 200000);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk(req_ready == 1 && resp_valid == 0 && walk_req == 0, "R1 idle after reset",
        {29'b0, req_ready, resp_valid, walk_req}, 32'h4);
    chk(bad_vaddr == 0, "R1 bad_vaddr reset", bad_vaddr, 0);

    access(0, 32'h0001_2345, 0, mkpte(20'h80, E|UR|UW), 1, 0, 32'h0008_0345, "R4 load miss");
    access(0, 32'h0001_2FFF, 0, '0, 0, 0, 32'h0008_0FFF, "R3 load hit");
    access(1, 32'h0001_2010, 0, '0, 0, 0, 32'h0008_0010, "R8 store hit on rw page");
    access(2, 32'h0001_2000, 0, mkpte(20'h80, E|UR|UW), 1, 3, 0, "R8 fetch misses rw page");
    chk(bad_vaddr == 0, "R9 fetch fault keeps bad_vaddr", bad_vaddr, 0);
    access(0, 32'h0001_2004, 0, '0, 0, 0, 32'h0008_0004, "R7 fault kept entry");

    access(0, 32'h0011_2000, 0, mkpte(20'h33, E|UR), 1, 0, 32'h0003_3000, "R2 alias index replaces");
    access(1, 32'h0011_2004, 0, mkpte(20'h33, E|UR), 1, 2, 0, "R8 store on read-only page");
    chk(bad_vaddr == 32'h0011_2004, "R9 store fault address", bad_vaddr, 32'h0011_2004);
    access(0, 32'h0011_2008, 0, '0, 0, 0, 32'h0003_3008, "R7 store fault no install");
    access(0, 32'h0001_2345, 0, mkpte(20'h80, E|UR), 1, 0, 32'h0008_0345, "R2 evicted page misses");

    access(0, 32'h0040_5010, 1, mkpte(20'h7, E|SR), 1, 0, 32'h0000_7010, "R6 supervisor read");
    access(0, 32'h0050_6000, 0, mkpte(20'h7, E|SR), 1, 1, 0, "R6 user lacks read");
    chk(bad_vaddr == 32'h0050_6000, "R9 load fault address", bad_vaddr, 32'h0050_6000);
    access(2, 32'h0060_7000, 1, mkpte(20'h9, E|UR|UW|UX), 1, 3, 0, "R6 supervisor ignores user x");
    access(2, 32'h0060_7100, 1, mkpte(20'h9, E|SX), 1, 0, 32'h0000_9100, "R6 supervisor exec");
    access(1, 32'h0090_A000, 1, mkpte(20'hA, E|SW), 1, 0, 32'h0000_A000, "R6 supervisor write");
    access(0, 32'h0070_8000, 0, mkpte(20'h5, UR|UW|UX|SR), 1, 1, 0, "R5 no valid bit");
    access(0, 32'h0040_5020, 0, '0, 0, 0, 32'h0000_7020, "R3 hit uses cached tag");

    // flush together with a request: held back, then misses
    @(posedge clk); #1;
    flush = 1; req_valid = 1; req_kind = 0; req_vaddr = 32'h0001_2345; supv = 0;
    @(posedge clk); #1;
    chk(resp_valid == 0 && walk_req == 0, "R10 request held during flush",
        {30'b0, resp_valid, walk_req}, 0);
    flush = 0;
    @(posedge clk); #1;
    req_valid = 0;
    chk(walk_req == 1, "R10 miss after flush", 32'(walk_req), 1);
    serve_walk(mkpte(20'h80, E|UR));
    chk(resp_valid == 1 && resp_paddr == 32'h0008_0345, "R10 refill after flush",
        resp_paddr, 32'h0008_0345);

    @(posedge clk); #1; flush = 1;
    @(posedge clk); #1; flush = 0;
    access(0, 32'hFFFF_FFFF, 0, mkpte(20'h1, E|UR), 1, 0, 32'h0000_1FFF, "R1 all-ones address misses");
    access(2, 32'h0040_5000, 1, mkpte(20'h7, E|SX), 1, 0, 32'h0000_7000, "R10 flushed page walks");

    repeat (3) @(posedge clk);
    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule